// File: doc/BRIEF.md
# PCIe MSI Receive and Interrupt Controller

This block sits on the inbound memory-write path of a PCIe root complex and picks out message-signalled interrupts. Each inbound write is compared against a programmed 64-bit target address. When the address matches, the block claims the write and checks its data against a programmed value under a programmed mask. A claimed write whose data matches sets one bit in a 32-bit pending register. That bit is chosen by the low data bits left uncovered by the mask. Writes the block does not claim leave on a registered pass-through port unchanged, one cycle later.

The pending bits are read and modified through set, write-one-to-clear and mask set/clear/status views on a simple 32-bit register bus. A registered level interrupt output stays high while any unmasked pending bit is set. Masking gates only the output, so interrupts keep latching while masked. A build-time legacy option places 8 vectors at pending bits 24 to 31 instead of 32 vectors starting at bit 0.

Top module: `msi_rx_ctrl`

## Requirements
- R1: After synchronous reset, all pending bits are 0, every implemented mask bit is 1, the target-address registers and data configuration read 0 (so detection is disabled), and `irq` is 0.
- R2: An inbound write is claimed when all of the following hold:
  - target-low bit 0 (the enable) is 1;
  - the address equals the target address {target-high, target-low}, with bit 0 ignored;
  - `in_be` is 4'hF;
  - `in_single` is 1.
  A claimed write with data[31:16] = 0 and ((data[15:0] XOR value) AND mask) = 0 sets pending bit `base + (data[15:0] AND NOT mask)` at the next clock edge. Here mask is config[31:16], value is config[15:0], and base is 0 in full mode.
- R3: A write that is not claimed appears on `pt_valid/pt_addr/pt_data/pt_be/pt_single` one cycle later with identical fields and leaves the pending register unchanged.
- R4: A claimed write is never forwarded (`pt_valid` stays 0 in the next cycle). If its data does not match, it changes no pending bit.
- R5: The number of trailing zero bits in the mask sets how many vectors the data can select (0xFFE0 gives 32, 0xFFF8 gives 8). A vector at or above the implemented vector count is dropped.
- R6: Writing the clear register (offset 0x08) clears exactly the pending bits written as 1. Bits written as 0 are unaffected.
- R7: Writing the set register (offset 0x04) sets the implemented pending bits written as 1. Writes to the pending-status offset 0x00 have no effect.
- R8: Mask set (0x10) and mask clear (0x14) set or clear mask bits written as 1, and mask status (0x0C) reads the mask. A masked vector still latches into the pending register.
- R9: `irq` is high exactly when some pending bit is set whose mask bit is 0. It updates on the same clock edge as the pending and mask registers, so it falls once all unmasked pending bits are cleared.
- R10: When a matching interrupt and a clear-register write hit the same pending bit in the same cycle, the bit ends up set.
- R11: With LEGACY=1 only 8 vectors exist, and vector n maps to pending bit n+24. Pending and mask bits 0 to 23 always read 0 and cannot be set.
- R12: Register map:
  - 0x00 pending status;
  - 0x0C mask status;
  - 0x20 target-low (bit 0 = enable);
  - 0x24 target-high;
  - 0x28 data configuration (mask in [31:16], value in [15:0]).
  Read data appears on `reg_rdata` in the cycle after `reg_rd`. Other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| in_valid | input | 1 | Inbound memory write present |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data (first beat) |
| in_be | input | 4 | Inbound byte enables |
| in_single | input | 1 | Write is a single data beat |
| pt_valid | output | 1 | Forwarded write present |
| pt_addr | output | 64 | Forwarded address |
| pt_data | output | 32 | Forwarded data |
| pt_be | output | 4 | Forwarded byte enables |
| pt_single | output | 1 | Forwarded single-beat flag |
| irq | output | 1 | Level interrupt, any unmasked pending bit |

## Verification
The bench builds two copies side by side from one stimulus stream: one with LEGACY=0 (32 vectors at bit 0) and one with LEGACY=1 (8 vectors at bits 24 to 31). Every interrupt therefore shows both the plain bit placement and the offset placement. Because the two copies differ in vector count, one vector (20) is latched by the full copy and dropped by the legacy one. Writes to low pending and mask bits also show that the legacy copy keeps bits 0 to 23 at zero.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_PEND   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_SET    = 8'h04;
  localparam logic [REG_AW-1:0] OFS_CLR    = 8'h08;
  localparam logic [REG_AW-1:0] OFS_MSTAT  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_MSET   = 8'h10;
  localparam logic [REG_AW-1:0] OFS_MCLR   = 8'h14;
  localparam logic [REG_AW-1:0] OFS_TGT_LO = 8'h20;
  localparam logic [REG_AW-1:0] OFS_TGT_HI = 8'h24;
  localparam logic [REG_AW-1:0] OFS_DCFG   = 8'h28;

  localparam int MSG_W = 16;
endpackage

// File: rtl/msi_rx_cfg.sv
module msi_rx_cfg
  import msi_rx_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] tgt_lo_q,
  output logic [REG_W-1:0] tgt_hi_q,
  output logic [REG_W-1:0] dcfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
      dcfg_q   <= '0;
    end else if (wr) begin
      case (addr)
        OFS_TGT_LO: tgt_lo_q <= wdata;
        OFS_TGT_HI: tgt_hi_q <= wdata;
        OFS_DCFG:   dcfg_q   <= wdata;
        default: ;
      endcase
    end
  end

  a_r1_cfg_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tgt_lo_q == '0 && tgt_hi_q == '0 && dcfg_q == '0));
endmodule

// File: rtl/msi_rx_match.sv
module msi_rx_match
  import msi_rx_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 64,
  parameter int NUM_VEC  = 32,
  parameter int VEC_BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [REG_W-1:0]  in_data,
  input  logic [3:0]        in_be,
  input  logic              in_single,
  input  logic              enable,
  input  logic [ADDR_W-1:0] target,
  input  logic [MSG_W-1:0]  dmask,
  input  logic [MSG_W-1:0]  dval,
  output logic [REG_W-1:0]  hit_oh,
  output logic              pt_valid,
  output logic [ADDR_W-1:0] pt_addr,
  output logic [REG_W-1:0]  pt_data,
  output logic [3:0]        pt_be,
  output logic              pt_single
);
  logic             addr_eq;
  logic             claim;
  logic             data_ok;
  logic [MSG_W-1:0] vec;

  assign addr_eq = (((in_addr ^ target) >> 1) == '0);
  assign claim   = in_valid && enable && addr_eq && (in_be == 4'hF) && in_single;
  assign data_ok = (in_data[REG_W-1:MSG_W] == '0) &&
                   (((in_data[MSG_W-1:0] ^ dval) & dmask) == '0);
  assign vec     = in_data[MSG_W-1:0] & ~dmask;

  for (genvar g = 0; g < REG_W; g++) begin : g_vec
    if (g >= VEC_BASE && g < VEC_BASE + NUM_VEC) begin : g_impl
      assign hit_oh[g] = claim && data_ok && (vec == MSG_W'(g - VEC_BASE));
    end else begin : g_none
      assign hit_oh[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pt_valid <= 1'b0;
    end else begin
      pt_valid <= in_valid && !claim;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pt_addr   <= '0;
      pt_data   <= '0;
      pt_be     <= '0;
      pt_single <= 1'b0;
    end else if (in_valid && !claim) begin
      pt_addr   <= in_addr;
      pt_data   <= in_data;
      pt_be     <= in_be;
      pt_single <= in_single;
    end
  end

  // R3: unclaimed writes leave one cycle later unchanged
  a_r3_forward: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !claim) |=> (pt_valid && pt_data == $past(in_data) &&
                              pt_addr == $past(in_addr) && pt_be == $past(in_be)));
  // R4: claimed writes are consumed
  a_r4_consumed: assert property (@(posedge clk) disable iff (rst)
    (in_valid && claim) |=> !pt_valid);
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_oh));
endmodule

// File: rtl/msi_rx_status.sv
module msi_rx_status #(
  parameter int               REG_W = 32,
  parameter logic [REG_W-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] hit_oh,
  input  logic [REG_W-1:0] sw_set,
  input  logic [REG_W-1:0] sw_clr,
  input  logic [REG_W-1:0] sw_mset,
  input  logic [REG_W-1:0] sw_mclr,
  output logic [REG_W-1:0] pend_q,
  output logic [REG_W-1:0] mask_q,
  output logic             irq_q
);
  logic [REG_W-1:0] pend_nxt;
  logic [REG_W-1:0] mask_nxt;

  always_comb begin
    pend_nxt = (((pend_q | sw_set) & ~sw_clr) | hit_oh) & IMPL;
    mask_nxt = ((mask_q | sw_mset) & ~sw_mclr) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= IMPL;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      mask_q <= mask_nxt;
      irq_q  <= |(pend_nxt & ~mask_nxt);
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pend_q == '0 && mask_q == IMPL && !irq_q));
  a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(pend_q & ~mask_q));
  // R2 and R10: a hit always lands, even against a clear
  a_r10_hit_wins: assert property (@(posedge clk) disable iff (rst)
    (|hit_oh) |=> ((pend_q & $past(hit_oh)) == $past(hit_oh)));
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    ((|sw_clr) && hit_oh == '0) |=> ((pend_q & $past(sw_clr)) == '0));
  a_r11_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~IMPL) == '0) && ((mask_q & ~IMPL) == '0));
endmodule

// File: rtl/msi_rx_ctrl.sv
module msi_rx_ctrl
  import msi_rx_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int LEG_VEC = 8,
  parameter bit LEGACY  = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                in_valid,
  input  logic [2*REG_W-1:0]  in_addr,
  input  logic [REG_W-1:0]    in_data,
  input  logic [3:0]          in_be,
  input  logic                in_single,
  output logic                pt_valid,
  output logic [2*REG_W-1:0]  pt_addr,
  output logic [REG_W-1:0]    pt_data,
  output logic [3:0]          pt_be,
  output logic                pt_single,
  output logic                irq
);
  localparam int ADDR_W   = 2 * REG_W;
  localparam int NUM_VEC  = LEGACY ? LEG_VEC : REG_W;
  localparam int VEC_BASE = LEGACY ? REG_W - LEG_VEC : 0;
  localparam logic [REG_W-1:0] IMPL = ({REG_W{1'b1}} >> (REG_W - NUM_VEC)) << VEC_BASE;

  logic [REG_W-1:0] tgt_lo, tgt_hi, dcfg;
  logic [REG_W-1:0] hit_oh, pend, mask;
  logic [REG_W-1:0] sw_set, sw_clr, sw_mset, sw_mclr;
  logic [REG_W-1:0] rd_mux;

  assign sw_set  = (reg_wr && reg_addr == OFS_SET)  ? reg_wdata : '0;
  assign sw_clr  = (reg_wr && reg_addr == OFS_CLR)  ? reg_wdata : '0;
  assign sw_mset = (reg_wr && reg_addr == OFS_MSET) ? reg_wdata : '0;
  assign sw_mclr = (reg_wr && reg_addr == OFS_MCLR) ? reg_wdata : '0;

  msi_rx_cfg #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .tgt_lo_q(tgt_lo), .tgt_hi_q(tgt_hi), .dcfg_q(dcfg)
  );

  msi_rx_match #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC), .VEC_BASE(VEC_BASE)
  ) u_match (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .in_be(in_be), .in_single(in_single),
    .enable(tgt_lo[0]), .target({tgt_hi, tgt_lo}),
    .dmask(dcfg[REG_W-1:MSG_W]), .dval(dcfg[MSG_W-1:0]),
    .hit_oh(hit_oh),
    .pt_valid(pt_valid), .pt_addr(pt_addr), .pt_data(pt_data),
    .pt_be(pt_be), .pt_single(pt_single)
  );

  msi_rx_status #(.REG_W(REG_W), .IMPL(IMPL)) u_status (
    .clk(clk), .rst(rst), .hit_oh(hit_oh),
    .sw_set(sw_set), .sw_clr(sw_clr), .sw_mset(sw_mset), .sw_mclr(sw_mclr),
    .pend_q(pend), .mask_q(mask), .irq_q(irq)
  );

  always_comb begin
    case (reg_addr)
      OFS_PEND:   rd_mux = pend;
      OFS_MSTAT:  rd_mux = mask;
      OFS_TGT_LO: rd_mux = tgt_lo;
      OFS_TGT_HI: rd_mux = tgt_hi;
      OFS_DCFG:   rd_mux = dcfg;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
    end
  end

  // R12: a read of pending status returns the value held at the strobe
  a_r12_read_pend: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_PEND) |=> (reg_rdata == $past(pend)));
endmodule

// File: tb/test_msi_rx_ctrl.sv
module test_msi_rx_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        in_valid, in_single;
  logic [63:0] in_addr;
  logic [31:0] in_data;
  logic [3:0]  in_be;

  logic [31:0] rd_f, rd_l;
  logic        ptv_f, ptv_l, pts_f, pts_l, irq_f, irq_l;
  logic [63:0] pta_f, pta_l;
  logic [31:0] ptd_f, ptd_l;
  logic [3:0]  ptb_f, ptb_l;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [63:0] TGT = 64'h0000_0010_FEE0_0000;

  always #5 clk = ~clk;

  msi_rx_ctrl #(.LEGACY(1'b0)) i_msi_rx_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_f), .in_valid(in_valid), .in_addr(in_addr),
    .in_data(in_data), .in_be(in_be), .in_single(in_single), .pt_valid(ptv_f),
    .pt_addr(pta_f), .pt_data(ptd_f), .pt_be(ptb_f), .pt_single(pts_f), .irq(irq_f)
  );

  msi_rx_ctrl #(.LEGACY(1'b1)) i_msi_rx_ctrl_legacy (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_l), .in_valid(in_valid), .in_addr(in_addr),
    .in_data(in_data), .in_be(in_be), .in_single(in_single), .pt_valid(ptv_l),
    .pt_addr(pta_l), .pt_data(ptd_l), .pt_be(ptb_l), .pt_single(pts_l), .irq(irq_l)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] f, output logic [31:0] l);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    f = rd_f; l = rd_l;
  endtask

  task automatic send(input logic [63:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic single);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d; in_be = be; in_single = single;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_pend(input string tag, input logic [31:0] ef, input logic [31:0] el);
    logic [31:0] f, l;
    rd(8'h00, f, l);
    chk({tag, " full pending"}, f, ef);
    chk({tag, " legacy pending"}, l, el);
  endtask

  task automatic t_reset();
    logic [31:0] f, l;
    chk("R1 irq full", irq_f, 0);
    chk("R1 irq legacy", irq_l, 0);
    chk_pend("R1", 0, 0);
    rd(8'h0C, f, l);
    chk("R1 mask full", f, 32'hFFFF_FFFF);
    chk("R11 R1 mask legacy", l, 32'hFF00_0000);
    rd(8'h20, f, l);
    chk("R1 target-low", f, 0);
  endtask

  task automatic t_disabled();
    wr(8'h24, TGT[63:32]);
    wr(8'h20, TGT[31:0]);
    wr(8'h28, 32'hFFE0_6540);
    wr(8'h14, 32'hFFFF_FFFF);
    send(TGT, 32'h6545, 4'hF, 1'b1);
    chk("R3 disabled forwarded", ptv_f, 1);
    chk("R3 disabled data", ptd_f, 32'h6545);
    chk("R3 disabled addr", pta_f, TGT);
    chk_pend("R3 disabled", 0, 0);
  endtask

  task automatic t_accept();
    logic [31:0] f, l;
    wr(8'h20, TGT[31:0] | 32'h1);
    send(TGT, 32'h6545, 4'hF, 1'b1);
    chk("R4 claimed not forwarded", ptv_f, 0);
    chk("R2 irq full", irq_f, 1);
    chk("R9 irq legacy", irq_l, 1);
    chk_pend("R2 R11 vec5", 32'h0000_0020, 32'h2000_0000);
    send(TGT, 32'h7545, 4'hF, 1'b1);
    chk("R4 mismatch not forwarded", ptv_f, 0);
    chk_pend("R4 mismatch", 32'h0000_0020, 32'h2000_0000);
    send(TGT, 32'h6554, 4'hF, 1'b1);
    chk_pend("R5 vec20", 32'h0010_0020, 32'h2000_0000);
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R9 irq falls", irq_f, 0);
    chk_pend("R6 clear all", 0, 0);
    rd(8'h24, f, l);
    chk("R12 target-high", f, TGT[63:32]);
  endtask

  task automatic t_forward();
    send(TGT ^ 64'h1_0000_0000, 32'h6541, 4'hF, 1'b1);
    chk("R3 addr miss valid", ptv_f, 1);
    chk("R3 addr miss addr", pta_f, TGT ^ 64'h1_0000_0000);
    send(TGT, 32'h6541, 4'h3, 1'b1);
    chk("R3 partial valid", ptv_f, 1);
    chk("R3 partial be", ptb_f, 4'h3);
    send(TGT, 32'h6541, 4'hF, 1'b0);
    chk("R3 multi-beat valid", ptv_f, 1);
    chk("R3 multi-beat single", pts_f, 0);
    chk_pend("R3 forwarded", 0, 0);
  endtask

  task automatic t_mask();
    logic [31:0] f, l;
    wr(8'h10, 32'hFFFF_FFFF);
    send(TGT, 32'h6543, 4'hF, 1'b1);
    chk("R8 masked irq", irq_f, 0);
    chk_pend("R8 masked latch", 32'h8, 32'h0800_0000);
    rd(8'h0C, f, l);
    chk("R8 mask status", f, 32'hFFFF_FFFF);
    wr(8'h14, 32'h8);
    chk("R8 unmask irq full", irq_f, 1);
    chk("R11 unmask low irq legacy", irq_l, 0);
    wr(8'h14, 32'h0800_0000);
    chk("R8 unmask irq legacy", irq_l, 1);
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R9 clear drops irq", irq_l, 0);
    wr(8'h14, 32'hFFFF_FFFF);
  endtask

  task automatic t_set();
    wr(8'h04, 32'h8000_0001);
    chk_pend("R7 R11 set", 32'h8000_0001, 32'h8000_0000);
    wr(8'h00, 32'h0);
    chk_pend("R7 pend write ignored", 32'h8000_0001, 32'h8000_0000);
    wr(8'h08, 32'h1);
    chk_pend("R6 partial clear", 32'h8000_0000, 32'h8000_0000);
    wr(8'h08, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    wr(8'h04, 32'h3);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'hFFFF_FFFF;
    in_valid = 1'b1; in_addr = TGT; in_data = 32'h6542; in_be = 4'hF; in_single = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; in_valid = 1'b0;
    chk_pend("R10 msi beats clear", 32'h4, 32'h0400_0000);
    wr(8'h08, 32'hFFFF_FFFF);
  endtask

  task automatic t_eight();
    logic [31:0] f, l;
    wr(8'h28, 32'hFFF8_6540);
    send(TGT, 32'h6548, 4'hF, 1'b1);
    chk("R5 8-vector mismatch consumed", ptv_f, 0);
    chk_pend("R5 8-vector mismatch", 0, 0);
    send(TGT, 32'h6546, 4'hF, 1'b1);
    chk_pend("R5 R11 8-vector vec6", 32'h40, 32'h4000_0000);
    rd(8'h28, f, l);
    chk("R12 data config", f, 32'hFFF8_6540);
    rd(8'h30, f, l);
    chk("R12 unmapped reads 0", f, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    in_valid = 1'b0; in_addr = '0; in_data = '0; in_be = '0; in_single = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_accept();
    t_forward();
    t_mask();
    t_set();
    t_race();
    t_eight();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule